// File: doc/BRIEF.md
# Serial Front-End Select and Lock Controller

This block chooses which serial front end, an I2C-style engine or an SPI-style engine, owns the path to the register file. After a power-on reset it selects I2C and is unlocked. It watches the chip-select pin through a synchroniser and edge detector, and counts complete pulses on that pin. A complete pulse is a high-to-low transition followed by a low-to-high transition. When a fixed number of complete pulses arrives without a long static gap, the block commits to SPI. That commitment cannot be undone by any input except another power-on reset.

The mode output drives the mux between the two protocol engines. A read-only status byte shows the lock state. A software reset clears any partly counted pulse pattern but leaves the chosen interface alone. Holding chip-select at either static level keeps the part in I2C mode indefinitely.

Top module: `ifsel_lock_ctrl`

## Requirements
- R1: A power-on reset (`por_rst` high at a clock edge) sets `spi_sel` and `lock_status` to 0 and makes the status byte read 00h.
- R2: With `N_PULSES` = 4, the fourth complete low-high pulse on `cs_pin` sets `spi_sel` and `lock_status` to 1 (1 means SPI). The change appears exactly at the third rising clock edge that samples `cs_pin` high for that final rise, and not at the second.
- R3: Fewer than `N_PULSES` complete pulses leave the block in I2C mode (`spi_sel` = 0).
- R4: If `cs_pin` is static for `TIMEOUT` clocks (default 64), partial pulse progress is discarded, and a full `N_PULSES` fresh pulses are needed afterwards. A static gap of at most `TIMEOUT`-8 clocks keeps the progress.
- R5: `sw_rst` never changes `spi_sel` or `lock_status` once SPI is locked.
- R6: `sw_rst` discards partial pulse progress, so `N_PULSES` complete pulses after it are needed to lock.
- R7: Once locked, `spi_sel` returns to 0 only through `por_rst`.
- R8: `rd_data` is registered. One clock after `rd_addr` is presented it shows the byte for that address. Address 7Fh returns the lock state in bit 0 and zeros in bits 7:1. Every other address returns 00h.
- R9: Further activity on `cs_pin` after the lock has no effect on `spi_sel`.
- R10: `cs_pin` held low or held high for any length of time never locks the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Synchronous active-high power-on reset; the only way to leave SPI mode |
| sw_rst | input | 1 | Synchronous active-high software reset; clears pulse progress only |
| cs_pin | input | 1 | Asynchronous chip-select pin |
| rd_addr | input | AW | Register address presented for a status read |
| spi_sel | output | 1 | Front-end mux select: 0 = I2C engine, 1 = SPI engine |
| lock_status | output | 1 | 1 when SPI mode is locked |
| rd_data | output | DW | Registered read data for `rd_addr` |

## Verification
A rise on `cs_pin` passes through two synchroniser flops and one edge-detect register before it reaches the lock flop. The lock therefore appears at the third clock edge after the pin rises. The bench checks one edge early for 0 and then at that third edge for 1. Status reads are due one edge after the address is driven, and the bench samples them at the following falling edge. Counting and timeout results are checked only after six or more quiet clocks, so the pipeline has drained before the expected lock state is compared.

// File: rtl/ifsel_pkg.sv
package ifsel_pkg;

  typedef enum logic {
    MODE_I2C = 1'b0,
    MODE_SPI = 1'b1
  } if_mode_e;

  // Status byte: lock flag in bit 0, all other bits zero.
  function automatic logic [7:0] status_byte(input logic locked);
    return {7'b0, locked};
  endfunction

endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
  parameter int    STAGES   = 2,
  parameter logic  IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_LVL}};
      last  <= IDLE_LVL;
    end else begin
      chain[0] <= pin;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;

endmodule

// File: rtl/pulse_pattern_cnt.sv
module pulse_pattern_cnt #(
  parameter int N_PULSES = 4,
  parameter int TIMEOUT  = 64
) (
  input  logic clk,
  input  logic por_rst,
  input  logic sw_rst,
  input  logic rise,
  input  logic fall,
  output logic hit
);

  localparam int CW = $clog2(N_PULSES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(N_PULSES - 1);
  localparam logic [TW-1:0] IDLE_MAX = TW'(TIMEOUT - 1);

  logic          armed;
  logic [CW-1:0] cnt;
  logic [TW-1:0] idle;
  logic          busy;

  assign busy = armed | (cnt != '0);
  assign hit  = rise & armed & (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (por_rst || sw_rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      idle  <= '0;
    end else if (rise || fall) begin
      idle <= '0;
      if (fall) armed <= 1'b1;
      if (rise && armed) begin
        armed <= 1'b0;
        cnt   <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
      end
    end else if (busy) begin
      if (idle == IDLE_MAX) begin
        armed <= 1'b0;
        cnt   <= '0;
        idle  <= '0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ifsel_lock_ctrl.sv
module ifsel_lock_ctrl
  import ifsel_pkg::*;
#(
  parameter int            N_PULSES    = 4,
  parameter int            TIMEOUT     = 64,
  parameter int            SYNC_STAGES = 2,
  parameter int            AW          = 8,
  parameter int            DW          = 8,
  parameter logic [AW-1:0] STATUS_ADDR = 8'h7F
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          sw_rst,
  input  logic          cs_pin,
  input  logic [AW-1:0] rd_addr,
  output logic          spi_sel,
  output logic          lock_status,
  output logic [DW-1:0] rd_data
);

  logic     cs_rise, cs_fall, pattern_hit;
  if_mode_e mode_q;

  cs_edge_sync #(
    .STAGES  (SYNC_STAGES),
    .IDLE_LVL(1'b1)
  ) u_sync (
    .clk (clk),
    .rst (por_rst),
    .pin (cs_pin),
    .rise(cs_rise),
    .fall(cs_fall)
  );

  pulse_pattern_cnt #(
    .N_PULSES(N_PULSES),
    .TIMEOUT (TIMEOUT)
  ) u_cnt (
    .clk    (clk),
    .por_rst(por_rst),
    .sw_rst (sw_rst),
    .rise   (cs_rise),
    .fall   (cs_fall),
    .hit    (pattern_hit)
  );

  // One-way commitment: only power-on reset clears it.
  always_ff @(posedge clk) begin
    if (por_rst)          mode_q <= MODE_I2C;
    else if (pattern_hit) mode_q <= MODE_SPI;
  end

  always_ff @(posedge clk) begin
    if (por_rst)                     rd_data <= '0;
    else if (rd_addr == STATUS_ADDR) rd_data <= DW'(status_byte(mode_q == MODE_SPI));
    else                             rd_data <= '0;
  end

  assign spi_sel     = (mode_q == MODE_SPI);
  assign lock_status = (mode_q == MODE_SPI);

endmodule

// File: rtl/ifsel_lock_chk.sv
module ifsel_lock_chk #(
  parameter int            AW          = 8,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] STATUS_ADDR = 8'h7F
) (
  input logic          clk,
  input logic          por_rst,
  input logic          sw_rst,
  input logic          cs_pin,
  input logic [AW-1:0] rd_addr,
  input logic          spi_sel,
  input logic [DW-1:0] rd_data
);

  localparam int HW    = $clog2(SYNC_STAGES + 4) + 1;
  localparam int NEEDH = SYNC_STAGES + 2;

  logic [HW-1:0] hist;
  logic          hist_ok;
  logic          past_ok;

  always_ff @(posedge clk) begin
    if (por_rst)              hist <= '0;
    else if (!(&hist))        hist <= hist + 1'b1;
  end
  assign hist_ok = (hist >= HW'(NEEDH));
  assign past_ok = (hist != '0);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (por_rst)
    $fell(spi_sel) |-> $past(por_rst));

  // R5
  swrst_keep_chk: assert property (@(posedge clk) disable iff (por_rst)
    (sw_rst && spi_sel) |=> spi_sel);

  // R8
  status_pad_chk: assert property (@(posedge clk) disable iff (por_rst)
    rd_data[DW-1:1] == '0);

  // R8
  status_bit_chk: assert property (@(posedge clk) disable iff (por_rst)
    (past_ok && $past(rd_addr) == STATUS_ADDR) |-> (rd_data[0] == $past(spi_sel)));

  // R2
  lock_cause_chk: assert property (@(posedge clk) disable iff (por_rst)
    (hist_ok && $rose(spi_sel)) |->
      ($past(cs_pin, SYNC_STAGES + 1) && !$past(cs_pin, SYNC_STAGES + 2)));

endmodule

bind ifsel_lock_ctrl ifsel_lock_chk #(
  .AW         (AW),
  .DW         (DW),
  .SYNC_STAGES(SYNC_STAGES),
  .STATUS_ADDR(STATUS_ADDR)
) i_chk (
  .clk    (clk),
  .por_rst(por_rst),
  .sw_rst (sw_rst),
  .cs_pin (cs_pin),
  .rd_addr(rd_addr),
  .spi_sel(spi_sel),
  .rd_data(rd_data)
);

// File: tb/test_ifsel_lock_ctrl.sv
module test_ifsel_lock_ctrl;

  localparam int N       = 4;
  localparam int TIMEOUT = 64;

  logic       clk = 1'b0;
  logic       por_rst = 1'b1;
  logic       sw_rst = 1'b0;
  logic       cs_pin = 1'b1;
  logic [7:0] rd_addr = 8'h00;
  logic       spi_sel, lock_status;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ifsel_lock_ctrl #(.N_PULSES(N), .TIMEOUT(TIMEOUT)) i_ifsel_lock_ctrl (
    .clk(clk), .por_rst(por_rst), .sw_rst(sw_rst), .cs_pin(cs_pin),
    .rd_addr(rd_addr), .spi_sel(spi_sel), .lock_status(lock_status),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_status(input logic [7:0] a, input bit lk);
    return (a == 8'h7F) ? {7'b0, lk} : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por();
    por_rst = 1'b1; cs_pin = 1'b1; sw_rst = 1'b0;
    wait_n(3);
    por_rst = 1'b0;
    wait_n(2);
  endtask

  task automatic pulse(input int lo, input int hi);
    cs_pin = 1'b0; wait_n(lo);
    cs_pin = 1'b1; wait_n(hi);
  endtask

  task automatic rnd_pulses(input int k);
    for (int i = 0; i < k; i++) pulse($urandom_range(1, 6), $urandom_range(3, 6));
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input bit lk);
    rd_addr = a;
    wait_n(1);
    chk(req, rd_data, exp_status(a, lk));
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    wait_n(1);
    do_por();
    // R1 reset state
    chk("R1 spi_sel", {7'b0, spi_sel}, 8'h00);
    chk("R1 lock_status", {7'b0, lock_status}, 8'h00);
    read_chk("R1 status", 8'h7F, 1'b0);

    // R3 one short of the pattern
    rnd_pulses(N - 1);
    wait_n(8);
    chk("R3 spi_sel", {7'b0, spi_sel}, 8'h00);
    read_chk("R8 status unlocked", 8'h7F, 1'b0);

    // R2 final pulse with exact latency
    cs_pin = 1'b0; wait_n(3);
    cs_pin = 1'b1;
    wait_n(2);
    chk("R2 not early", {7'b0, spi_sel}, 8'h00);
    wait_n(1);
    chk("R2 spi_sel", {7'b0, spi_sel}, 8'h01);
    chk("R2 lock_status", {7'b0, lock_status}, 8'h01);
    read_chk("R8 status locked", 8'h7F, 1'b1);
    read_chk("R8 other addr 00", 8'h00, 1'b1);
    read_chk("R8 other addr 7E", 8'h7E, 1'b1);

    // R9 more activity after lock
    rnd_pulses(10);
    cs_pin = 1'b0; wait_n(100); cs_pin = 1'b1; wait_n(8);
    chk("R9 spi_sel", {7'b0, spi_sel}, 8'h01);

    // R5 software reset keeps lock
    sw_rst = 1'b1; wait_n(1); sw_rst = 1'b0; wait_n(4);
    chk("R5 spi_sel", {7'b0, spi_sel}, 8'h01);
    read_chk("R5 status", 8'h7F, 1'b1);

    // R7 only power-on reset unlocks
    do_por();
    chk("R7 spi_sel", {7'b0, spi_sel}, 8'h00);

    // R10 static levels never lock
    cs_pin = 1'b0; wait_n(150);
    cs_pin = 1'b1; wait_n(150);
    chk("R10 static", {7'b0, spi_sel}, 8'h00);

    // R4 timeout discards progress
    do_por();
    rnd_pulses(N - 1);
    wait_n(TIMEOUT + 10);
    pulse(2, 3); wait_n(6);
    chk("R4 after timeout", {7'b0, spi_sel}, 8'h00);
    rnd_pulses(N - 2); wait_n(6);
    chk("R4 one short", {7'b0, spi_sel}, 8'h00);
    pulse(2, 3); wait_n(6);
    chk("R4 fresh pattern", {7'b0, spi_sel}, 8'h01);

    // R4 gap below timeout keeps progress
    do_por();
    for (int i = 0; i < N - 1; i++) pulse(2, 2);
    wait_n(TIMEOUT - 10);
    pulse(2, 2); wait_n(6);
    chk("R4 short gap", {7'b0, spi_sel}, 8'h01);

    // R6 software reset discards progress
    do_por();
    rnd_pulses(N - 1);
    sw_rst = 1'b1; wait_n(1); sw_rst = 1'b0;
    pulse(2, 3); wait_n(6);
    chk("R6 after sw_rst", {7'b0, spi_sel}, 8'h00);
    rnd_pulses(N - 2); wait_n(6);
    chk("R6 one short", {7'b0, spi_sel}, 8'h00);
    pulse(2, 3); wait_n(6);
    chk("R6 full", {7'b0, spi_sel}, 8'h01);

    // R2 R3 random counts
    for (int r = 0; r < 8; r++) begin
      int k;
      k = $urandom_range(0, 2 * N);
      do_por();
      rnd_pulses(k);
      wait_n(6);
      chk((k >= N) ? "R2 random" : "R3 random", {7'b0, spi_sel}, (k >= N) ? 8'h01 : 8'h00);
      read_chk("R8 random", 8'h7F, (k >= N));
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule